// File: doc/BRIEF.md
# Dual-Channel Digital Phase Detector with Lock Indication

This block holds the digital part of the phase comparison for two synthesizer loops, an IF loop and an RF loop. Each channel watches a reference pulse train and a divided-feedback pulse train. Both trains are sampled on the oscillator clock. The channel reports which train's rising edge came first, and drives a pump request for as many oscillator cycles as the edges are apart. The request is given as an enable and a drive level: enable low means the analog stage floats its output. A polarity input per channel picks which way the request points, so it can match the VCO and filter slope.

The same phase-error count drives a lock detector in each channel. A channel becomes locked only after several comparisons in a row fall inside a small error window. A single wide comparison clears the lock at once. A channel held in power save floats its pump request and forgets its lock. The first correction after power save ends is clipped to a few cycles, so the VCO does not jump. One shared output pin carries the combined lock flag. It is high only when every channel is either locked or in power save. The pin can also be switched to monitor any one of the four raw pulse trains.

Top module: `dual_pd_lock`

## Requirements
- R1: When the reference edge comes D oscillator cycles before the feedback edge (D >= 1), the pump enable is high for exactly D cycles. During those cycles the drive level equals the channel's polarity input.
- R2: When the feedback edge comes D cycles before the reference edge, the pump enable is high for exactly D cycles. During those cycles the drive level is the inverse of the polarity input.
- R3: Polarity input 0 swaps the drive level of R1 and R2. The IF and RF channels each use their own polarity input.
- R4: Reference and feedback edges sampled in the same cycle give a balanced anti-dead-zone pair. The enable is high for 2*DZ_CYC cycles (default 2). The drive equals the polarity for the first DZ_CYC cycles and is its inverse for the rest.
- R5: A channel becomes locked after LOCK_CNT (default 3) consecutive completed comparisons whose error is below WIN_ERR (default 2) cycles. Coincident edges count as error 0.
- R6: A completed comparison with error >= WIN_ERR clears that channel's lock in the next cycle.
- R7: While a channel's run input is low (power save), its pump enable is low. Its lock state and consecutive-comparison count are cleared.
- R8: After run returns high, the enable of the first comparison is limited to LIMIT_CYC (default 3) cycles. Later comparisons are not limited.
- R9: With the monitor select off, the pin equals the AND over both channels of (locked OR run low).
- R10: With the monitor select on, mon_sel_i chooses the pin source: 2'b00 IF reference, 2'b01 RF reference, 2'b10 IF feedback, 2'b11 RF feedback.
- R11: During and right after reset, with run_if_i high and run_rf_i low, both pump enables are low and the pin reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fr_if_i | input | 1 | IF reference pulse train |
| fp_if_i | input | 1 | IF divided feedback pulse train |
| fr_rf_i | input | 1 | RF reference pulse train |
| fp_rf_i | input | 1 | RF divided feedback pulse train |
| pol_if_i | input | 1 | IF polarity (1: drive high when reference leads) |
| pol_rf_i | input | 1 | RF polarity |
| run_if_i | input | 1 | IF run, low selects power save |
| run_rf_i | input | 1 | RF run, low selects power save |
| mon_en_i | input | 1 | 1: pin shows a pulse train, 0: pin shows lock |
| mon_sel_i | input | 2 | Monitor source select |
| if_pump_en_o | output | 1 | IF pump drive enable (0 = float) |
| if_pump_val_o | output | 1 | IF pump drive level |
| rf_pump_en_o | output | 1 | RF pump drive enable |
| rf_pump_val_o | output | 1 | RF pump drive level |
| ld_mon_o | output | 1 | Combined lock flag or monitored pulse train |

## Verification
The first cycle after power save ends can do two jobs at once. The correction that cycle starts is clipped by R8, and its error still goes into the lock history of R5 and R6. The bench releases power save and sends a 6-cycle lead. It expects a 3-cycle pump burst, then a full 6-cycle burst on the next comparison. It also expects the pin to stay low until three narrow comparisons in a row have passed. Coincident edges put the dead-zone pair and a lock-counting comparison in the same cycle. The bench judges the two-cycle balanced burst, and it judges the lock result those coincident edges leave behind.

// File: rtl/dual_pd_pkg.sv
package dual_pd_pkg;

  typedef enum logic [1:0] {
    PD_IDLE,
    PD_LEAD,
    PD_LAG,
    PD_DZ
  } pd_state_e;

  localparam int unsigned NCH = 2;
  localparam int unsigned CH_IF = 0;
  localparam int unsigned CH_RF = 1;

endpackage

// File: rtl/pd_channel.sv
module pd_channel
  import dual_pd_pkg::*;
#(
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned DZ_CYC    = 1,
  parameter int unsigned LIMIT_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pol_i,
  input  logic             fr_i,
  input  logic             fp_i,
  output logic             pump_en_o,
  output logic             pump_val_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_o
);

  localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};
  localparam logic [ERR_W-1:0] DZ_HALF = ERR_W'(DZ_CYC);
  localparam logic [ERR_W-1:0] DZ_END  = ERR_W'(2 * DZ_CYC);
  localparam logic [ERR_W-1:0] LIM     = ERR_W'(LIMIT_CYC);

  logic             fr_q, fp_q;
  logic             fr_rise, fp_rise;
  pd_state_e        state_q, state_d;
  logic [ERR_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             relax_q, relax_d;
  logic             done;
  logic [ERR_W-1:0] err;

  assign fr_rise = fr_i & ~fr_q;
  assign fp_rise = fp_i & ~fp_q;
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    err     = cnt_q;
    unique case (state_q)
      PD_IDLE: begin
        if (fr_rise && fp_rise) begin
          state_d = PD_DZ;
          cnt_d   = ERR_W'(1);
          done    = 1'b1;
          err     = '0;
        end else if (fr_rise) begin
          state_d = PD_LEAD;
          cnt_d   = ERR_W'(1);
        end else if (fp_rise) begin
          state_d = PD_LAG;
          cnt_d   = ERR_W'(1);
        end
      end
      PD_LEAD: begin
        if (fp_rise) begin
          state_d = PD_IDLE;
          cnt_d   = '0;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      PD_LAG: begin
        if (fr_rise) begin
          state_d = PD_IDLE;
          cnt_d   = '0;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      PD_DZ: begin
        if (cnt_q >= DZ_END) begin
          state_d = PD_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: begin
        state_d = PD_IDLE;
        cnt_d   = '0;
      end
    endcase
    if (!run_i) begin
      state_d = PD_IDLE;
      cnt_d   = '0;
      done    = 1'b0;
    end
  end

  // clipping stays armed from power save until the first comparison completes
  always_comb begin
    relax_d = relax_q;
    if (!run_i)    relax_d = 1'b1;
    else if (done) relax_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q    <= 1'b0;
      fp_q    <= 1'b0;
      state_q <= PD_IDLE;
      cnt_q   <= '0;
      relax_q <= 1'b0;
    end else begin
      fr_q    <= fr_i;
      fp_q    <= fp_i;
      state_q <= state_d;
      cnt_q   <= cnt_d;
      relax_q <= relax_d;
    end
  end

  always_comb begin
    pump_en_o  = 1'b0;
    pump_val_o = 1'b0;
    unique case (state_q)
      PD_LEAD: begin
        pump_en_o  = !relax_q || (cnt_q <= LIM);
        pump_val_o = pol_i;
      end
      PD_LAG: begin
        pump_en_o  = !relax_q || (cnt_q <= LIM);
        pump_val_o = ~pol_i;
      end
      PD_DZ: begin
        pump_en_o  = 1'b1;
        pump_val_o = (cnt_q <= DZ_HALF) ? pol_i : ~pol_i;
      end
      default: begin
        pump_en_o  = 1'b0;
        pump_val_o = 1'b0;
      end
    endcase
    if (!run_i) pump_en_o = 1'b0;
  end

  assign done_o = done;
  assign err_o  = err;

endmodule

// File: rtl/pd_lock_det.sv
module pd_lock_det #(
  parameter int unsigned ERR_W    = 8,
  parameter int unsigned WIN_ERR  = 2,
  parameter int unsigned LOCK_CNT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             done_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             lock_o
);

  localparam int unsigned GW = $clog2(LOCK_CNT + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_CNT - 1);
  localparam logic [ERR_W-1:0] WIN = ERR_W'(WIN_ERR);

  logic [GW-1:0] good_q;
  logic          lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (!run_i) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (done_i) begin
      if (err_i >= WIN) begin
        good_q <= '0;
        lock_q <= 1'b0;
      end else if (good_q >= GOOD_LAST) begin
        lock_q <= 1'b1;
      end else begin
        good_q <= good_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;

endmodule

// File: rtl/pd_pin_mux.sv
module pd_pin_mux
  import dual_pd_pkg::*;
(
  input  logic           mon_en_i,
  input  logic [1:0]     mon_sel_i,
  input  logic [NCH-1:0] lock_i,
  input  logic [NCH-1:0] run_i,
  input  logic [NCH-1:0] fr_i,
  input  logic [NCH-1:0] fp_i,
  output logic           pin_o
);

  logic [NCH-1:0] ok;
  logic           mon;

  assign ok = lock_i | ~run_i;

  // bit 0 picks the channel, bit 1 picks feedback over reference
  always_comb begin
    unique case (mon_sel_i)
      2'b00:   mon = fr_i[CH_IF];
      2'b01:   mon = fr_i[CH_RF];
      2'b10:   mon = fp_i[CH_IF];
      default: mon = fp_i[CH_RF];
    endcase
  end

  assign pin_o = mon_en_i ? mon : &ok;

endmodule

// File: rtl/dual_pd_lock.sv
module dual_pd_lock
  import dual_pd_pkg::*;
#(
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned DZ_CYC    = 1,
  parameter int unsigned LIMIT_CYC = 3,
  parameter int unsigned WIN_ERR   = 2,
  parameter int unsigned LOCK_CNT  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fr_if_i,
  input  logic       fp_if_i,
  input  logic       fr_rf_i,
  input  logic       fp_rf_i,
  input  logic       pol_if_i,
  input  logic       pol_rf_i,
  input  logic       run_if_i,
  input  logic       run_rf_i,
  input  logic       mon_en_i,
  input  logic [1:0] mon_sel_i,
  output logic       if_pump_en_o,
  output logic       if_pump_val_o,
  output logic       rf_pump_en_o,
  output logic       rf_pump_val_o,
  output logic       ld_mon_o
);

  logic [NCH-1:0]   fr_w, fp_w, pol_w, run_w;
  logic [NCH-1:0]   en_w, val_w, done_w, lock_w;
  logic [ERR_W-1:0] err_w [NCH];

  assign fr_w  = {fr_rf_i, fr_if_i};
  assign fp_w  = {fp_rf_i, fp_if_i};
  assign pol_w = {pol_rf_i, pol_if_i};
  assign run_w = {run_rf_i, run_if_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pd_channel #(
      .ERR_W    (ERR_W),
      .DZ_CYC   (DZ_CYC),
      .LIMIT_CYC(LIMIT_CYC)
    ) u_pd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_w[c]),
      .pol_i     (pol_w[c]),
      .fr_i      (fr_w[c]),
      .fp_i      (fp_w[c]),
      .pump_en_o (en_w[c]),
      .pump_val_o(val_w[c]),
      .done_o    (done_w[c]),
      .err_o     (err_w[c])
    );

    pd_lock_det #(
      .ERR_W   (ERR_W),
      .WIN_ERR (WIN_ERR),
      .LOCK_CNT(LOCK_CNT)
    ) u_lock (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_w[c]),
      .done_i(done_w[c]),
      .err_i (err_w[c]),
      .lock_o(lock_w[c])
    );
  end

  pd_pin_mux u_pin (
    .mon_en_i (mon_en_i),
    .mon_sel_i(mon_sel_i),
    .lock_i   (lock_w),
    .run_i    (run_w),
    .fr_i     (fr_w),
    .fp_i     (fp_w),
    .pin_o    (ld_mon_o)
  );

  assign if_pump_en_o  = en_w[CH_IF];
  assign if_pump_val_o = val_w[CH_IF];
  assign rf_pump_en_o  = en_w[CH_RF];
  assign rf_pump_val_o = val_w[CH_RF];

endmodule

// File: rtl/dual_pd_lock_chk.sv
module dual_pd_lock_chk #(
  parameter int unsigned ERR_W   = 8,
  parameter int unsigned WIN_ERR = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_if_i,
  input logic             if_pump_en_o,
  input logic [1:0]       done_i,
  input logic [ERR_W-1:0] err_if_i,
  input logic [1:0]       lock_i
);

  // R7
  run_low_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_if_i |-> !if_pump_en_o);

  // R5
  lock_after_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_i[0]) |-> $past(done_i[0]));

  // R6
  wide_err_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i[0] && err_if_i >= ERR_W'(WIN_ERR)) |=> !lock_i[0]);

  // R4
  dead_zone_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i[0] && err_if_i == '0 && run_if_i) |=> (if_pump_en_o || !run_if_i));

endmodule

bind dual_pd_lock dual_pd_lock_chk #(
  .ERR_W  (ERR_W),
  .WIN_ERR(WIN_ERR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_if_i    (run_if_i),
  .if_pump_en_o(if_pump_en_o),
  .done_i      (done_w),
  .err_if_i    (err_w[0]),
  .lock_i      (lock_w)
);

// File: tb/dual_pd_lock_tb.sv
module dual_pd_lock_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr_if = 0, fp_if = 0, fr_rf = 0, fp_rf = 0;
  logic pol_if = 1, pol_rf = 1, run_if = 1, run_rf = 0, mon_en = 0;
  logic [1:0] mon_sel = 2'b00;
  logic if_en, if_val, rf_en, rf_val, ld;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dual_pd_lock u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fr_if_i(fr_if), .fp_if_i(fp_if), .fr_rf_i(fr_rf), .fp_rf_i(fp_rf),
    .pol_if_i(pol_if), .pol_rf_i(pol_rf), .run_if_i(run_if), .run_rf_i(run_rf),
    .mon_en_i(mon_en), .mon_sel_i(mon_sel),
    .if_pump_en_o(if_en), .if_pump_val_o(if_val),
    .rf_pump_en_o(rf_en), .rf_pump_val_o(rf_val), .ld_mon_o(ld)
  );

  typedef struct packed {
    logic signed [7:0] d;
    logic              pol;
    logic [7:0]        hi;
    logic [7:0]        lo;
  } vec_t;

  // d > 0: reference leads by d cycles; d < 0: feedback leads; d = 0: coincident
  localparam vec_t VECS [7] = '{
    '{8'sd3,  1'b1, 8'd3, 8'd0},
    '{-8'sd2, 1'b1, 8'd0, 8'd2},
    '{8'sd4,  1'b0, 8'd0, 8'd4},
    '{-8'sd1, 1'b0, 8'd1, 8'd0},
    '{8'sd0,  1'b1, 8'd1, 8'd1},
    '{8'sd0,  1'b0, 8'd1, 8'd1},
    '{8'sd7,  1'b1, 8'd7, 8'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one comparison on channel ch; counts enabled cycles by drive level
  task automatic run_pair(input int ch, input int d, output int hi, output int lo);
    int a, b, span;
    a = (d < 0) ? -d : 0;
    b = (d > 0) ? d : 0;
    span = ((d < 0) ? -d : d) + 8;
    hi = 0;
    lo = 0;
    for (int k = 0; k < span; k++) begin
      @(negedge clk);
      if (ch == 0) begin
        if (if_en) begin if (if_val) hi++; else lo++; end
        fr_if = (k == a);
        fp_if = (k == b);
      end else begin
        if (rf_en) begin if (rf_val) hi++; else lo++; end
        fr_rf = (k == a);
        fp_rf = (k == b);
      end
    end
    fr_if = 0; fp_if = 0; fr_rf = 0; fp_rf = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    check("R11 if_en in reset", int'(if_en), 0);
    check("R11 pin in reset", int'(ld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 rf_en after reset", int'(rf_en), 0);
    check("R11 pin after reset", int'(ld), 0);

    // R1 R2 R3 R4 table
    foreach (VECS[i]) begin
      pol_if = VECS[i].pol;
      run_pair(0, int'(VECS[i].d), hi, lo);
      check($sformatf("R1/R2/R3/R4 vec%0d high", i), hi, int'(VECS[i].hi));
      check($sformatf("R1/R2/R3/R4 vec%0d low", i), lo, int'(VECS[i].lo));
    end
    pol_if = 1;

    // R8 clipped first correction after power save
    @(negedge clk); run_if = 0;
    repeat (3) @(negedge clk);
    run_if = 1;
    run_pair(0, 6, hi, lo);
    check("R8 first burst clipped", hi, 3);
    run_pair(0, 6, hi, lo);
    check("R8 second burst full", hi, 6);

    // R5 R6 lock history
    run_pair(0, 1, hi, lo);
    run_pair(0, 1, hi, lo);
    check("R5 two narrow not locked", int'(ld), 0);
    run_pair(0, 1, hi, lo);
    check("R5 third narrow locked", int'(ld), 1);
    run_pair(0, -3, hi, lo);
    check("R6 wide error unlocks", int'(ld), 0);
    run_pair(0, 0, hi, lo);
    run_pair(0, -1, hi, lo);
    run_pair(0, 1, hi, lo);
    check("R5 relock with coincident", int'(ld), 1);

    // R9 combine
    run_rf = 1; @(negedge clk);
    check("R9 rf unlocked pulls low", int'(ld), 0);
    run_rf = 0; @(negedge clk);
    check("R9 rf power save counts locked", int'(ld), 1);

    // R7 power save
    run_if = 0; @(negedge clk);
    check("R7 both power save pin", int'(ld), 1);
    run_pair(0, 4, hi, lo);
    check("R7 no drive in power save", hi + lo, 0);
    run_if = 1; @(negedge clk);
    check("R7 lock cleared", int'(ld), 0);

    // R3 RF channel with own polarity
    run_rf = 1; pol_rf = 0;
    run_pair(1, 3, hi, lo);
    check("R3 rf lead low level", lo, 3);
    check("R3 rf lead no high", hi, 0);
    run_rf = 0;

    // R10 monitor select
    mon_en = 1;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      mon_sel = 2'(s);
      {fp_rf, fp_if, fr_rf, fr_if} = 4'(1 << s);
      #2 check($sformatf("R10 sel%0d only chosen high", s), int'(ld), 1);
      {fp_rf, fp_if, fr_rf, fr_if} = ~4'(1 << s);
      #2 check($sformatf("R10 sel%0d others high", s), int'(ld), 0);
    end
    {fp_rf, fp_if, fr_rf, fr_if} = 4'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule